// File: doc/BRIEF.md
# Paravirtual Device Register Front-End

This block is the register window that a guest driver sees for a legacy paravirtual I/O device. Software reaches it through a byte-addressed request/response port that accepts 8-, 16- and 32-bit accesses. The common area holds these registers:

- a read-only host feature word;
- a guest feature word;
- a queue selector, with a base page number, a size and an interrupt vector for the selected queue;
- a device status byte;
- an interrupt status byte that clears when it is read;
- a configuration-change vector.

Any access beyond the common area goes out on a device-specific configuration port. The common area is 20 bytes long while message-signalled interrupts are off and 24 bytes long while they are on.

Device-side logic raises events through plain pulse inputs: a queue event with its queue index, and a configuration-change event. The block turns them into interrupt status bits. It then drives either a level interrupt line or a one-cycle message request that carries a vector number. Writing zero to the status register or to the queue page register resets the device state in a single clock.

Top module: `pvreg_frontend`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read puts `rsp_valid` high after that edge, with `rsp_rdata`, and holds both unchanged until `rsp_ready` is seen high. `req_ready` is low while an unaccepted response is held. Writes return no response.
- R2: A read at offset 0 returns `dev_features` with bits 24, 28 and 30 forced to 1. Read data is masked to the access size: `req_size` 0 is a byte (bits 7:0), 1 is a halfword (bits 15:0), and 2 or 3 is a word. Write data is masked the same way.
- R3: The guest feature word at offset 4 stores the written value. If bit 30 of the written value is set, the parameter `FALLBACK_FEATURES` (default 0) is stored instead.
- R4: A write at offset 14 changes the queue selector only when the value is below `NUM_QUEUES`; other values are ignored. Offset 14 reads back the selector. Offset 8 is the page number of the selected queue. Offset 12 reads `QUEUE_SIZE`.
- R5: The status byte at offset 18 keeps the low 8 bits of a write. A write whose low 8 bits are 0 to offset 18, or a write of 0 to offset 8, resets the device in one clock. The reset clears the guest features, status, interrupt status, selector and all page numbers, sets every vector to 0xFFFF, and pulses `dev_reset` for one cycle after the accepting edge.
- R6: Bit 0 of the interrupt status byte (offset 19) is set by a queue event and bit 1 by a configuration event. A read of offset 19 returns the current value and clears it. An event in the same cycle as the read stays set.
- R7: `irq` equals bit 0 of the interrupt status while `msi_en` is low and is 0 while `msi_en` is high.
- R8: While `msi_en` is high, offset 20 is the configuration vector and offset 22 is the vector of the selected queue. A written value of `NUM_VECTORS` or more is stored as 0xFFFF.
- R9: While `msi_en` is high, a queue event pulses `msg_valid` one cycle later with that queue's vector, and a configuration event does the same with the configuration vector. No message is sent for vector 0xFFFF. When both events arrive together, the queue message goes first and the configuration message follows in the next cycle.
- R10: Accesses at or above offset 20 (`msi_en` low) or offset 24 (`msi_en` high) pulse `cfg_valid` in the accepting cycle, with `cfg_addr` equal to the offset minus that base. A read of this region returns `cfg_rdata` sampled in the accepting cycle.
- R11: Reads of unused common offsets (for example 1, 2 and 13) return all ones, masked to the access size. Writes to them and to the read-only offsets 0, 12 and 19 change nothing.
- R12: A write at offset 16 pulses `notify_valid` for one cycle after the accepting edge, with `notify_queue` equal to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read response data |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| dev_features | input | 32 | Device feature bits |
| ev_queue_valid | input | 1 | Queue event pulse |
| ev_queue_idx | input | SEL_W | Queue of the event |
| ev_cfg | input | 1 | Configuration-change event pulse |
| irq | output | 1 | Level interrupt |
| msg_valid | output | 1 | Message request pulse |
| msg_vector | output | 16 | Vector of the message |
| notify_valid | output | 1 | Queue notify pulse |
| notify_queue | output | 16 | Notified queue number |
| cfg_valid | output | 1 | Device configuration access |
| cfg_write | output | 1 | Configuration access is a write |
| cfg_addr | output | ADDR_W | Offset within the configuration region |
| cfg_size | output | 2 | Configuration access size |
| cfg_wdata | output | 32 | Configuration write data, masked |
| cfg_rdata | input | 32 | Configuration read data |
| dev_reset | output | 1 | Device reset pulse |

## Verification
On every cycle, assertions check these behaviours:

- the selector stays in range and every vector is either valid or 0xFFFF;
- a response is held steady under back-pressure;
- a reset leaves the status, features and vectors cleared;
- an interrupt-status read with no coinciding event empties the register;
- a message never carries 0xFFFF.

Only the bench's scenarios can show the rest:

- the exact values returned;
- feature fallback and bit forcing;
- how the window moves with `msi_en`;
- message ordering when both events arrive together;
- the forwarding offsets.

Its random phase compares selector, page-number and vector traffic against a bench-side model.

// File: rtl/pvreg_pkg.sv
package pvreg_pkg;
  localparam int OFS_HOSTF   = 0;
  localparam int OFS_GUESTF  = 4;
  localparam int OFS_PFN     = 8;
  localparam int OFS_QSIZE   = 12;
  localparam int OFS_QSEL    = 14;
  localparam int OFS_NOTIFY  = 16;
  localparam int OFS_STATUS  = 18;
  localparam int OFS_ISR     = 19;
  localparam int OFS_CFGVEC  = 20;
  localparam int OFS_QVEC    = 22;
  localparam int COMMON_PLAIN = 20;
  localparam int COMMON_MSG   = 24;
  localparam int BAD_FEAT_BIT = 30;
  localparam logic [31:0] FIXED_FEATS = 32'h5100_0000;
  localparam logic [15:0] NO_VEC = 16'hFFFF;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pvreg_queue_bank.sv
module pvreg_queue_bank #(
  parameter int NUM_QUEUES  = 4,
  parameter int NUM_VECTORS = 3,
  localparam int SEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_sel,
  input  logic             wr_pfn,
  input  logic             wr_qvec,
  input  logic             wr_cfgvec,
  input  logic [31:0]      wd,
  input  logic [SEL_W-1:0] ev_idx,
  output logic [SEL_W-1:0] qsel,
  output logic [31:0]      sel_pfn,
  output logic [15:0]      sel_qvec,
  output logic [15:0]      cfg_vec,
  output logic [15:0]      ev_vec
);
  import pvreg_pkg::*;

  logic [NUM_QUEUES-1:0][31:0] pfn_all;
  logic [NUM_QUEUES-1:0][15:0] vec_all;
  logic [15:0] new_vec;
  logic        clr;

  assign clr     = !rst_n || soft_rst;
  assign new_vec = (32'(wd[15:0]) < 32'(NUM_VECTORS)) ? wd[15:0] : NO_VEC;

  always_ff @(posedge clk) begin
    if (clr) begin
      qsel    <= '0;
      cfg_vec <= NO_VEC;
    end else begin
      if (wr_sel && (wd < 32'(NUM_QUEUES))) qsel <= wd[SEL_W-1:0];
      if (wr_cfgvec) cfg_vec <= new_vec;
    end
  end

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
    logic [31:0] pfn_r;
    logic [15:0] vec_r;
    always_ff @(posedge clk) begin
      if (clr) begin
        pfn_r <= '0;
        vec_r <= NO_VEC;
      end else if (qsel == SEL_W'(g)) begin
        if (wr_pfn)  pfn_r <= wd;
        if (wr_qvec) vec_r <= new_vec;
      end
    end
    assign pfn_all[g] = pfn_r;
    assign vec_all[g] = vec_r;
  end

  assign sel_pfn  = pfn_all[qsel];
  assign sel_qvec = vec_all[qsel];
  assign ev_vec   = (32'(ev_idx) < 32'(NUM_QUEUES)) ? vec_all[ev_idx] : NO_VEC;

  assert_qsel_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(qsel) < 32'(NUM_QUEUES));
  assert_cfgvec_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_vec == NO_VEC) || (32'(cfg_vec) < 32'(NUM_VECTORS)));
  assert_reset_vectors_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_vec == NO_VEC) && (qsel == '0) && (sel_pfn == '0));
endmodule

// File: rtl/pvreg_irq_unit.sv
module pvreg_irq_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        msi_en,
  input  logic        ev_queue_valid,
  input  logic [15:0] ev_vec,
  input  logic        ev_cfg,
  input  logic [15:0] cfg_vec,
  input  logic        rd_clr,
  output logic [7:0]  isr,
  output logic        irq,
  output logic        msg_valid,
  output logic [15:0] msg_vector
);
  import pvreg_pkg::*;

  logic cfg_pend;
  logic q_fire;
  logic c_want;

  assign q_fire = msi_en && ev_queue_valid && (ev_vec != NO_VEC);
  assign c_want = msi_en && (ev_cfg || cfg_pend) && (cfg_vec != NO_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      isr <= '0;
    end else begin
      isr <= (rd_clr ? 8'h00 : isr) | {6'b0, ev_cfg, ev_queue_valid};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= NO_VEC;
      cfg_pend   <= 1'b0;
    end else if (q_fire) begin
      msg_valid  <= 1'b1;
      msg_vector <= ev_vec;
      cfg_pend   <= c_want;
    end else if (c_want) begin
      msg_valid  <= 1'b1;
      msg_vector <= cfg_vec;
      cfg_pend   <= 1'b0;
    end else begin
      msg_valid  <= 1'b0;
      cfg_pend   <= 1'b0;
    end
  end

  assign irq = !msi_en && isr[0];

  assert_isr_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !soft_rst && !ev_queue_valid && !ev_cfg) |=> (isr == 8'h00));
  assert_msg_has_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_vector != NO_VEC));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev_queue_valid) || $past(msi_en)));
endmodule

// File: rtl/pvreg_frontend.sv
module pvreg_frontend #(
  parameter int          ADDR_W            = 8,
  parameter int          NUM_QUEUES        = 4,
  parameter int          NUM_VECTORS       = 3,
  parameter int          QUEUE_SIZE        = 256,
  parameter logic [31:0] FALLBACK_FEATURES = 32'h0,
  localparam int SEL_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              msi_en,
  input  logic [31:0]       dev_features,
  input  logic              ev_queue_valid,
  input  logic [SEL_W-1:0]  ev_queue_idx,
  input  logic              ev_cfg,
  output logic              irq,
  output logic              msg_valid,
  output logic [15:0]       msg_vector,
  output logic              notify_valid,
  output logic [15:0]       notify_queue,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [1:0]        cfg_size,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  output logic              dev_reset
);
  import pvreg_pkg::*;

  logic              acc;
  logic [31:0]       wmask;
  logic [31:0]       wd;
  logic [ADDR_W-1:0] common_len;
  logic              in_cfg;
  logic              wr_common;
  logic              rd_common;
  int                ofs;
  logic wr_gf, wr_pfn, wr_sel, wr_notify, wr_status, wr_cfgvec, wr_qvec;
  logic soft_rst;
  logic isr_rd;
  logic [31:0] rd_val;
  logic [31:0] guest_q;
  logic [7:0]  status_q;
  logic [SEL_W-1:0] qsel;
  logic [31:0] sel_pfn;
  logic [15:0] sel_qvec, cfg_vec, ev_vec;
  logic [7:0]  isr;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign wmask      = size_mask(req_size);
  assign wd         = req_wdata & wmask;
  assign common_len = msi_en ? ADDR_W'(COMMON_MSG) : ADDR_W'(COMMON_PLAIN);
  assign in_cfg     = req_addr >= common_len;
  assign wr_common  = acc && req_write && !in_cfg;
  assign rd_common  = acc && !req_write && !in_cfg;
  assign ofs        = int'(req_addr);

  assign wr_gf     = wr_common && (ofs == OFS_GUESTF);
  assign wr_pfn    = wr_common && (ofs == OFS_PFN);
  assign wr_sel    = wr_common && (ofs == OFS_QSEL);
  assign wr_notify = wr_common && (ofs == OFS_NOTIFY);
  assign wr_status = wr_common && (ofs == OFS_STATUS);
  assign wr_cfgvec = wr_common && msi_en && (ofs == OFS_CFGVEC);
  assign wr_qvec   = wr_common && msi_en && (ofs == OFS_QVEC);
  assign isr_rd    = rd_common && (ofs == OFS_ISR);
  assign soft_rst  = (wr_status && (wd[7:0] == 8'h00)) || (wr_pfn && (wd == 32'h0));

  pvreg_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .NUM_VECTORS(NUM_VECTORS)) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_sel(wr_sel), .wr_pfn(wr_pfn && (wd != 32'h0)), .wr_qvec(wr_qvec),
    .wr_cfgvec(wr_cfgvec), .wd(wd), .ev_idx(ev_queue_idx),
    .qsel(qsel), .sel_pfn(sel_pfn), .sel_qvec(sel_qvec),
    .cfg_vec(cfg_vec), .ev_vec(ev_vec)
  );

  pvreg_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .msi_en(msi_en),
    .ev_queue_valid(ev_queue_valid), .ev_vec(ev_vec), .ev_cfg(ev_cfg),
    .cfg_vec(cfg_vec), .rd_clr(isr_rd), .isr(isr), .irq(irq),
    .msg_valid(msg_valid), .msg_vector(msg_vector)
  );

  always_comb begin
    rd_val = 32'hFFFF_FFFF;
    if (in_cfg) begin
      rd_val = cfg_rdata;
    end else begin
      case (ofs)
        OFS_HOSTF:  rd_val = dev_features | FIXED_FEATS;
        OFS_GUESTF: rd_val = guest_q;
        OFS_PFN:    rd_val = sel_pfn;
        OFS_QSIZE:  rd_val = 32'(QUEUE_SIZE);
        OFS_QSEL:   rd_val = 32'(qsel);
        OFS_STATUS: rd_val = {24'h0, status_q};
        OFS_ISR:    rd_val = {24'h0, isr};
        OFS_CFGVEC: if (msi_en) rd_val = {16'h0, cfg_vec};
        OFS_QVEC:   if (msi_en) rd_val = {16'h0, sel_qvec};
        default:    rd_val = 32'hFFFF_FFFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      guest_q  <= '0;
      status_q <= '0;
    end else begin
      if (wr_gf)     guest_q  <= wd[BAD_FEAT_BIT] ? FALLBACK_FEATURES : wd;
      if (wr_status) status_q <= wd[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      notify_valid <= 1'b0;
      notify_queue <= '0;
      dev_reset    <= 1'b0;
    end else begin
      if (acc && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_val & wmask;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      notify_valid <= wr_notify;
      if (wr_notify) notify_queue <= wd[15:0];
      dev_reset <= soft_rst;
    end
  end

  assign cfg_valid = acc && in_cfg;
  assign cfg_write = req_write;
  assign cfg_addr  = req_addr - common_len;
  assign cfg_size  = req_size;
  assign cfg_wdata = wd;

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_q == 8'h00) && (guest_q == 32'h0) && dev_reset);
  assert_bad_feature_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gf && wd[BAD_FEAT_BIT]) |=> (guest_q == FALLBACK_FEATURES));
  assert_notify_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_notify |=> notify_valid);
endmodule

// File: tb/pvreg_frontend_test.sv
module pvreg_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int NV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic msi_en = 1'b0;
  logic [31:0] dev_features = 32'h0000_00A5;
  logic ev_queue_valid = 1'b0, ev_cfg = 1'b0;
  logic [1:0] ev_queue_idx = '0;
  logic irq, msg_valid, notify_valid, cfg_valid, cfg_write, dev_reset;
  logic [15:0] msg_vector, notify_queue;
  logic [7:0] cfg_addr;
  logic [1:0] cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata = 32'hCAFE_BEEF;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;
  logic seen_rst, seen_ntf, seen_cfg;
  logic [15:0] seen_nq;
  logic [7:0] seen_caddr;

  pvreg_frontend uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [15:0] v);
    return (32'(v) < NV) ? v : 16'hFFFF;
  endfunction
  function automatic logic [31:0] exp_gf(input logic [31:0] v);
    return v[30] ? 32'h0 : v;
  endfunction

  task automatic bus(input logic wr, input int addr, input logic [1:0] sz, input logic [31:0] wdat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 8'(addr); req_size = sz; req_wdata = wdat;
    #1;
    seen_cfg = cfg_valid; seen_caddr = cfg_addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    seen_rst = dev_reset; seen_ntf = notify_valid; seen_nq = notify_queue;
  endtask

  task automatic wr32(input int a, input logic [31:0] d); bus(1'b1, a, 2'd2, d); endtask
  task automatic rd32(input int a); bus(1'b0, a, 2'd2, 32'h0); endtask

  task automatic event_pulse(input logic q, input logic [1:0] idx, input logic c);
    @(negedge clk);
    ev_queue_valid = q; ev_queue_idx = idx; ev_cfg = c;
    @(negedge clk);
    ev_queue_valid = 1'b0; ev_cfg = 1'b0;
  endtask

  logic [31:0] m_pfn [NQ];
  logic [15:0] m_qv [NQ];
  logic [15:0] m_cv;
  logic [31:0] m_gf;
  int m_sel;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R7 reset irq", 32'(irq), 0);
    rd32(18); chk("R5 reset status", rd, 0);
    rd32(19); chk("R6 reset isr", rd, 0);

    rd32(0); chk("R2 host features", rd, 32'h5100_00A5);
    bus(1'b0, 0, 2'd0, 0); chk("R2 byte read", rd, 32'hA5);
    bus(1'b0, 0, 2'd1, 0); chk("R2 half read", rd, 32'h00A5);

    wr32(4, 32'h1234_5678); rd32(4); chk("R3 guest features", rd, 32'h1234_5678);
    wr32(4, 32'h4000_0001); rd32(4); chk("R3 bad-feature fallback", rd, 0);

    wr32(14, 2); rd32(14); chk("R4 qsel write", rd, 2);
    wr32(14, 9); rd32(14); chk("R4 qsel out of range ignored", rd, 2);
    wr32(8, 32'h0000_ABCD); rd32(8); chk("R4 pfn of queue 2", rd, 32'h0000_ABCD);
    wr32(14, 1); rd32(8); chk("R4 pfn of queue 1", rd, 0);
    rd32(12); chk("R4 queue size", rd, 256);

    rd32(2); chk("R11 unused word", rd, 32'hFFFF_FFFF);
    bus(1'b0, 13, 2'd0, 0); chk("R11 unused byte", rd, 32'hFF);
    wr32(4, 32'h0000_0033);
    wr32(1, 32'h0); wr32(0, 32'h0); wr32(12, 32'h0);
    rd32(4); chk("R11 write to unused/ro ignored", rd, 32'h33);
    rd32(0); chk("R11 host features unchanged", rd, 32'h5100_00A5);

    wr32(16, 32'h3); chk("R12 notify pulse", 32'(seen_ntf), 1);
    chk("R12 notify queue", 32'(seen_nq), 3);

    wr32(18, 32'h1F); rd32(18); chk("R5 status store", rd, 32'h1F);
    chk("R5 no reset on nonzero", 32'(seen_rst), 0);
    wr32(14, 2);
    wr32(18, 32'h100); chk("R5 status zero low byte resets", 32'(seen_rst), 1);
    rd32(4); chk("R5 guest cleared", rd, 0);
    rd32(14); chk("R5 qsel cleared", rd, 0);
    wr32(14, 2); rd32(8); chk("R5 pfn cleared", rd, 0);
    wr32(8, 32'h77); wr32(4, 32'h5);
    wr32(8, 32'h0); chk("R5 pfn zero resets", 32'(seen_rst), 1);
    rd32(4); chk("R5 guest cleared by pfn reset", rd, 0);

    event_pulse(1'b1, 2'd0, 1'b0);
    chk("R7 irq follows isr bit0", 32'(irq), 1);
    rd32(19); chk("R6 isr read value", rd, 1);
    chk("R7 irq dropped after read", 32'(irq), 0);
    rd32(19); chk("R6 isr cleared", rd, 0);
    event_pulse(1'b0, 2'd0, 1'b1);
    chk("R7 irq ignores bit1", 32'(irq), 0);
    rd32(19); chk("R6 config bit", rd, 2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd19; req_size = 2'd2; ev_queue_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; ev_queue_valid = 1'b0;
    chk("R6 read during event returns old", rsp_rdata, 0);
    rd32(19); chk("R6 coinciding event kept", rd, 1);

    bus(1'b0, 20, 2'd2, 0); chk("R10 cfg read plain", rd, 32'hCAFE_BEEF);
    chk("R10 cfg valid plain", 32'(seen_cfg), 1);
    chk("R10 cfg addr plain", 32'(seen_caddr), 0);
    msi_en = 1'b1;
    bus(1'b0, 26, 2'd2, 0); chk("R10 cfg addr msi", 32'(seen_caddr), 2);
    rd32(20); chk("R8 cfg vector reset value", rd, 32'hFFFF);
    chk("R10 offset 20 is common under msi", 32'(seen_cfg), 0);

    wr32(20, 1); rd32(20); chk("R8 cfg vector", rd, 1);
    wr32(20, 7); rd32(20); chk("R8 out-of-range vector", rd, 32'hFFFF);
    wr32(20, 1);
    wr32(14, 1); wr32(22, 2); rd32(22); chk("R8 queue vector", rd, 2);

    @(negedge clk); ev_queue_valid = 1'b1; ev_queue_idx = 2'd1; ev_cfg = 1'b1;
    @(negedge clk); ev_queue_valid = 1'b0; ev_cfg = 1'b0;
    chk("R9 first message valid", 32'(msg_valid), 1);
    chk("R9 first message queue vector", 32'(msg_vector), 2);
    chk("R7 no irq under msi", 32'(irq), 0);
    @(negedge clk);
    chk("R9 second message valid", 32'(msg_valid), 1);
    chk("R9 second message config vector", 32'(msg_vector), 1);
    @(negedge clk);
    chk("R9 message ends", 32'(msg_valid), 0);
    event_pulse(1'b1, 2'd3, 1'b0);
    chk("R9 no message for empty vector", 32'(msg_valid), 0);

    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd12; req_size = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    chk("R1 response valid", 32'(rsp_valid), 1);
    chk("R1 ready low under back-pressure", 32'(req_ready), 0);
    @(negedge clk); @(negedge clk);
    chk("R1 response held", rsp_rdata, 256);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R1 response released", 32'(rsp_valid), 0);

    wr32(18, 0);
    for (int i = 0; i < NQ; i++) begin m_pfn[i] = 0; m_qv[i] = 16'hFFFF; end
    m_cv = 16'hFFFF; m_sel = 0; m_gf = 0;
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 9);
      case (op)
        0: begin v = $urandom_range(0, 7); wr32(14, v); if (v < NQ) m_sel = int'(v); end
        1: begin v = $urandom | 32'h1; wr32(8, v); m_pfn[m_sel] = v; end
        2: begin v = ($urandom_range(0,1) != 0) ? 32'($urandom_range(0,5)) : 32'hFFFF;
                 wr32(22, v); m_qv[m_sel] = exp_vec(v[15:0]); end
        3: begin v = ($urandom_range(0,1) != 0) ? 32'($urandom_range(0,5)) : 32'hFFFF;
                 wr32(20, v); m_cv = exp_vec(v[15:0]); end
        4: begin rd32(8);  chk("R4 random pfn", rd, m_pfn[m_sel]); end
        5: begin rd32(22); chk("R8 random queue vector", rd, 32'(m_qv[m_sel])); end
        6: begin rd32(14); chk("R4 random qsel", rd, 32'(m_sel)); end
        7: begin rd32(20); chk("R8 random cfg vector", rd, 32'(m_cv)); end
        8: begin v = $urandom; wr32(4, v); m_gf = exp_gf(v); end
        default: begin rd32(4); chk("R3 random guest features", rd, m_gf); end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule